// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

A synthesizable model of a byte-wide serial EEPROM that answers as a slave on an SPI bus. A host selects it with an active-low chip select, clocks an 8-bit instruction in on SI and then any address or data bytes. Read data and status come back on SO. The bus pins are oversampled by the block's own system clock, so every SCK phase must last at least two system clock cycles. SCK may idle low or high (clock modes 0 and 3). SI is taken on each rising SCK edge and SO changes on each falling edge.

The storage is an internal register array of `DEPTH` bytes, 2048 by default with 1024 as the smaller option. A write first fills a page buffer of 16 bytes. Raising chip select after a whole number of data bytes starts a self-timed cycle of `WRITE_CYCLES` clocks that moves the buffered bytes into the array. A write-enable latch, two block-protect bits in the status byte and an active-low write-protect pin together decide what may change. An active-low hold pin pauses a transfer without deselecting the device.

Top module: `spi_eeprom`

## Requirements
- R1: After reset the status byte, read with instruction 0x05, is 0x00 and SO is not driven (so_oe low) while chip select is high.
- R2: Instruction 0x06 sets the write-enable latch, shown as status bit 1, and instruction 0x04 clears it.
- R3: A write (0x02) or a status write (0x01) sent while the write-enable latch is clear changes nothing and starts no write cycle.
- R4: Instruction 0x03 followed by a two-byte address, high byte first, returns bytes from consecutive addresses for as long as chip select stays low. Bytes sent with 0x02 and an address are stored at consecutive addresses.
- R5: Write data that runs past the end of a 16-byte page wraps to the start of the same page.
- R6: A sequential read wraps from the last address to address 0.
- R7: Status bits 3:2, set by instruction 0x01, protect nothing (00), the top quarter (01), the top half (10) or the whole array (11). Writes to protected addresses are discarded.
- R8: While wp_n is low, a status write is ignored and the latch stays set.
- R9: A write cycle starts when chip select rises. For WRITE_CYCLES clocks status bit 0 reads 1 and every instruction other than 0x05 is rejected. When the cycle ends, bit 0 and the write-enable latch both clear.
- R10: While hold_n is low with chip select low, SCK and SI are ignored and SO is not driven. The transfer resumes where it stopped once hold_n returns high.
- R11: A write or status write whose chip select rises after a partial byte is aborted: no cycle starts and the latch stays set.
- R12: Transfers with SCK idling high (mode 3) behave the same as with SCK idling low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low pause |
| wp_n | input | 1 | Active-low status write protect |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | High while SO is driven; low means high impedance |

## Verification
The assertions assume the bus pins change only between system clock edges and that each SCK level lasts at least two system clocks, so every edge is seen exactly once. They also assume the host never toggles SCK while chip select is high. The bench drives every pin on the falling system clock edge. It holds each SCK phase for two cycles, moves chip select only while SCK sits at its idle level, and changes hold_n only while SCK is high, so the stimulus stays inside those limits.

// File: rtl/spi_eeprom.sv
module spi_eeprom #(
  parameter int DEPTH        = 2048,
  parameter int PAGE         = 16,
  parameter int WRITE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic si,
  input  logic cs_n,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);
  localparam int TW = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_RD, S_WR, S_RDSR, S_WRSR, S_SKIP} st_t;

  st_t            st;
  logic           sck_d, cs_d, so_q;
  logic [2:0]     cnt;
  logic [6:0]     sh;
  logic           abyte, rd_op;
  logic [AW-9:0]  ahi;
  logic [AW-1:0]  addr;
  logic [7:0]     tx;
  logic           wel, busy, wr_got, sr_got;
  logic [TW-1:0]  tmr;
  logic [1:0]     bp, bp_new;
  logic [PW-1:0]  poff;
  logic [PW:0]    drain;
  logic [PAGE-1:0] pmask;
  logic [7:0]     pbuf [PAGE];
  logic [7:0]     mem  [DEPTH];

  wire        act   = !cs_n && hold_n;
  wire        rise  = act && sck && !sck_d;
  wire        fall  = act && !sck && sck_d;
  wire [7:0]  rx    = {sh, si};
  wire        bdone = rise && cnt == 3'd7;
  wire [7:0]  status = {4'b0, bp, wel, busy};
  wire [AW-1:0] a_in = {ahi, rx};
  wire [AW-1:0] wa   = {addr[AW-1:PW], drain[PW-1:0]};

  function automatic logic locked(input logic [AW-1:0] a, input logic [1:0] b);
    case (b)
      2'b00:   return 1'b0;
      2'b01:   return &a[AW-1:AW-2];
      2'b10:   return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  wire pb_we  = bdone && st == S_WR;
  wire mem_we = busy && !drain[PW] && pmask[drain[PW-1:0]] && !locked(wa, bp);

  assign so    = so_q;
  assign so_oe = act && (st == S_RD || st == S_RDSR);

  always_ff @(posedge clk) begin
    if (pb_we) pbuf[poff] <= rx;
    if (mem_we) mem[wa] <= pbuf[drain[PW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_CMD; sck_d <= 1'b0; cs_d <= 1'b1; so_q <= 1'b0;
      cnt <= '0; sh <= '0; abyte <= 1'b0; rd_op <= 1'b0; ahi <= '0;
      addr <= '0; tx <= '0; wel <= 1'b0; busy <= 1'b0; wr_got <= 1'b0;
      sr_got <= 1'b0; tmr <= '0; bp <= '0; bp_new <= '0; poff <= '0;
      drain <= '0; pmask <= '0;
    end else begin
      sck_d <= sck;
      cs_d  <= cs_n;
      if (busy) begin
        tmr <= tmr - 1'b1;
        if (tmr == TW'(1)) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end
        if (!drain[PW]) drain <= drain + 1'b1;
      end
      if (cs_n) begin
        st <= S_CMD; cnt <= '0; abyte <= 1'b0;
        wr_got <= 1'b0; sr_got <= 1'b0;
        if (!cs_d && cnt == 3'd0) begin
          if (st == S_WR && wr_got) begin
            busy <= 1'b1; tmr <= TW'(WRITE_CYCLES); drain <= '0;
          end
          if (st == S_WRSR && sr_got) begin
            bp <= bp_new;
            busy <= 1'b1; tmr <= TW'(WRITE_CYCLES); drain <= (PW+1)'(PAGE);
          end
        end
      end else if (rise) begin
        sh  <= rx[6:0];
        cnt <= cnt + 1'b1;
        if (cnt == 3'd7) begin
          case (st)
            S_CMD: begin
              if (rx == 8'h05) begin
                st <= S_RDSR; tx <= status;
              end else if (busy) st <= S_SKIP;
              else case (rx)
                8'h03: begin st <= S_ADDR; rd_op <= 1'b1; end
                8'h02: begin st <= wel ? S_ADDR : S_SKIP; rd_op <= 1'b0; end
                8'h06: begin wel <= 1'b1; st <= S_SKIP; end
                8'h04: begin wel <= 1'b0; st <= S_SKIP; end
                8'h01: st <= (wel && wp_n) ? S_WRSR : S_SKIP;
                default: st <= S_SKIP;
              endcase
            end
            S_ADDR: begin
              abyte <= 1'b1;
              if (!abyte) ahi <= rx[AW-9:0];
              else begin
                addr <= a_in;
                if (rd_op) begin
                  st <= S_RD; tx <= mem[a_in];
                end else begin
                  st <= S_WR; poff <= a_in[PW-1:0]; pmask <= '0;
                end
              end
            end
            S_RD: begin
              addr <= addr + 1'b1;
              tx   <= mem[addr + 1'b1];
            end
            S_WR: begin
              pmask[poff] <= 1'b1;
              poff   <= poff + 1'b1;
              wr_got <= 1'b1;
            end
            S_RDSR: tx <= status;
            S_WRSR: begin bp_new <= rx[3:2]; sr_got <= 1'b1; end
            default: ;
          endcase
        end
      end else if (fall) begin
        so_q <= tx[~cnt];
      end
    end
  end

  assert_cycle_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wel);
  assert_wel_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  assert_busy_blocks_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> st != S_RD && st != S_WR);
  assert_bp_moves_at_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $rose(busy));
  assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !cs_n) |=> $stable(cnt));
endmodule

// File: tb/spi_eeprom_test.sv
module spi_eeprom_test;
  logic clk = 0, rst_n = 0, sck = 0, si = 0, cs_n = 1, hold_n = 1, wp_n = 1;
  logic so, so_oe;
  logic idle = 0;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];
  bit done = 0;

  always #10 clk = ~clk;

  spi_eeprom #(.WRITE_CYCLES(120)) uut (.clk(clk), .rst_n(rst_n), .sck(sck), .si(si),
    .cs_n(cs_n), .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0 && exp_q.size() > 0)
      chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
  end

  task automatic expect_b(input logic [7:0] v, input string tag);
    exp_q.push_back(v); tag_q.push_back(tag);
  endtask

  task automatic bitx(input logic b, output logic r);
    sck = 0; si = b;
    repeat (2) @(negedge clk);
    r = so; sck = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bitx(t[i], r[i]);
  endtask

  task automatic start();
    sck = idle; cs_n = 0; repeat (2) @(negedge clk);
  endtask

  task automatic stop();
    repeat (2) @(negedge clk); sck = idle; repeat (2) @(negedge clk);
    cs_n = 1; repeat (4) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    start(); xfer(op, r); stop();
  endtask

  task automatic rdsr(input logic [7:0] e, input string tag);
    logic [7:0] r;
    expect_b(e, tag);
    start(); xfer(8'h05, r); xfer(8'h00, r); got_q.push_back(r); stop();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    start(); xfer(8'h01, r); xfer(v, r); stop();
  endtask

  task automatic rd(input logic [10:0] a, input int n);
    logic [7:0] r;
    start(); xfer(8'h03, r); xfer({5'b0, a[10:8]}, r); xfer(a[7:0], r);
    for (int i = 0; i < n; i++) begin xfer(8'h00, r); got_q.push_back(r); end
    stop();
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d [4], input int n);
    logic [7:0] r;
    start(); xfer(8'h02, r); xfer({5'b0, a[10:8]}, r); xfer(a[7:0], r);
    for (int i = 0; i < n; i++) xfer(d[i], r);
    stop();
  endtask

  task automatic settle();
    repeat (150) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [4];
    logic [7:0] r;
    logic b;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 so_oe idle", {7'b0, so_oe}, 8'h00);
    rdsr(8'h00, "R1 status after reset");

    cmd1(8'h06); rdsr(8'h02, "R2 latch set");
    cmd1(8'h04); rdsr(8'h00, "R2 latch cleared");

    cmd1(8'h06);
    d = '{8'h11, 8'h22, 8'h33, 8'h00};
    wr(11'h010, d, 3);
    rdsr(8'h03, "R9 busy and latch during cycle");
    start(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h10, r);
    bitx(1'b0, b);
    chk("R9 read rejected while busy", {7'b0, so_oe}, 8'h00);
    stop();
    settle();
    rdsr(8'h00, "R9 cycle done, latch cleared");

    expect_b(8'h11, "R4 seq byte0"); expect_b(8'h22, "R4 seq byte1"); expect_b(8'h33, "R4 seq byte2");
    rd(11'h010, 3);

    d = '{8'hAA, 8'h00, 8'h00, 8'h00};
    wr(11'h010, d, 1);
    rdsr(8'h00, "R3 no cycle without latch");
    expect_b(8'h11, "R3 data unchanged"); rd(11'h010, 1);
    wrsr(8'h0C);
    rdsr(8'h00, "R3 status write without latch");

    cmd1(8'h06);
    d = '{8'hA0, 8'hA1, 8'hA2, 8'hA3};
    wr(11'h02E, d, 4); settle();
    expect_b(8'hA2, "R5 wrapped byte at page start"); expect_b(8'hA3, "R5 wrapped byte next");
    rd(11'h020, 2);
    expect_b(8'hA0, "R5 page end byte0"); expect_b(8'hA1, "R5 page end byte1");
    rd(11'h02E, 2);

    cmd1(8'h06); d = '{8'h5A, 8'h00, 8'h00, 8'h00}; wr(11'h7FF, d, 1); settle();
    cmd1(8'h06); d = '{8'hC3, 8'h00, 8'h00, 8'h00}; wr(11'h000, d, 1); settle();
    expect_b(8'h5A, "R6 last address"); expect_b(8'hC3, "R6 wrapped to zero");
    rd(11'h7FF, 2);

    cmd1(8'h06); d = '{8'h99, 8'h00, 8'h00, 8'h00}; wr(11'h600, d, 1); settle();
    cmd1(8'h06); wrsr(8'h04); settle();
    rdsr(8'h04, "R7 quarter protect set");
    cmd1(8'h06); d = '{8'h77, 8'h00, 8'h00, 8'h00}; wr(11'h600, d, 1); settle();
    cmd1(8'h06); d = '{8'h66, 8'h00, 8'h00, 8'h00}; wr(11'h5FF, d, 1); settle();
    expect_b(8'h66, "R7 unprotected written"); expect_b(8'h99, "R7 protected kept");
    rd(11'h5FF, 2);
    cmd1(8'h06); wrsr(8'h0C); settle();
    cmd1(8'h06); d = '{8'hEE, 8'h00, 8'h00, 8'h00}; wr(11'h010, d, 1); settle();
    expect_b(8'h11, "R7 whole array protected"); rd(11'h010, 1);
    cmd1(8'h06); wrsr(8'h00); settle();
    rdsr(8'h00, "R7 protection cleared");

    wp_n = 0;
    cmd1(8'h06); wrsr(8'h08);
    rdsr(8'h02, "R8 status write blocked by pin");
    wp_n = 1;
    cmd1(8'h04);

    cmd1(8'h06);
    start(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h30, r); xfer(8'h44, r);
    bitx(1'b1, b); bitx(1'b0, b); bitx(1'b1, b);
    stop();
    rdsr(8'h02, "R11 aborted write, latch kept");
    cmd1(8'h04);

    start(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h10, r);
    for (int i = 7; i >= 4; i--) bitx(1'b0, r[i]);
    hold_n = 0;
    repeat (2) @(negedge clk);
    chk("R10 SO released in hold", {7'b0, so_oe}, 8'h00);
    for (int i = 0; i < 4; i++) begin
      sck = 0; si = 1; repeat (2) @(negedge clk);
      sck = 1; repeat (2) @(negedge clk);
    end
    hold_n = 1;
    repeat (2) @(negedge clk);
    for (int i = 3; i >= 0; i--) bitx(1'b0, r[i]);
    expect_b(8'h11, "R10 byte across hold"); got_q.push_back(r);
    xfer(8'h00, r);
    expect_b(8'h22, "R10 next byte after hold"); got_q.push_back(r);
    stop();

    idle = 1; sck = 1; repeat (4) @(negedge clk);
    expect_b(8'hA2, "R12 mode3 byte0"); expect_b(8'hA3, "R12 mode3 byte1");
    rd(11'h020, 2);
    rdsr(8'h00, "R12 mode3 status");

    repeat (10) @(negedge clk);
    while (exp_q.size() > 0) begin
      errors++; checks++;
      $display("FAIL %s actual none expected %h", tag_q.pop_front(), exp_q.pop_front());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule